// File: doc/BRIEF.md
# Fail-first vector memory truncation unit

This block sits beside the element sequencer of a vector load/store pipe and decides what to do with each element's fault report. When a speculative fail-first operation is running, element 0 keeps ordinary semantics: a fault on it requests a precise exception. A fault on any later element shortens the vector length to that element's index and raises nothing. When fail-first is off, every fault in the active window becomes an exception and the length is left as it was.

For every response the unit also produces a writeback qualifier. That qualifier keeps faulted elements, and elements at or past the truncation point, out of the register file. An operation begins with a start pulse that carries the requested length and the mode flags. It ends when the response for the last element of the original length has been consumed. A build parameter selects the minimal policy, in which every fail-first operation is cut to length one from the start. Fail-first combined with indexed addressing, or with vertical-first stepping, is rejected as illegal and is not executed.

Top module: `ff_trunc_unit`

## Requirements
- R1: After reset, busy_o, done_o, exc_o, illegal_o and wb_en_o are 0 and vl_o is 0.
- R2: With fail-first enabled, a fault reported for element index 0 makes exc_o pulse for one cycle in the cycle after the response, and vl_o keeps its value.
- R3: With fail-first enabled, the first fault at an index k with 1 <= k < vl_o sets vl_o to k in the cycle after the response, and exc_o stays 0.
- R4: After the first fault that falls inside the window of an operation, whether it truncated or raised, later fault reports of that operation produce no exc_o and do not change vl_o.
- R5: wb_en_o is 1, in the same cycle as a response, only when the operation is busy, no earlier in-window fault has occurred, the response carries no fault, and its index is below vl_o.
- R6: With fail-first disabled, the first fault at any index below vl_o pulses exc_o in the next cycle, and vl_o stays equal to the requested length.
- R7: With FORCE_VL1=1, a legal fail-first start with a nonzero length sets vl_o to 1 one cycle after the start. Non-fail-first starts are not shortened.
- R8: A start with fail-first set together with indexed_i or vfirst_i pulses illegal_o for one cycle after the start, does not set busy_o, and leaves vl_o unchanged.
- R9: done_o pulses for one cycle after the response whose index equals the requested length minus 1, and busy_o falls in that same cycle. A legal start with length 0 pulses done_o in the next cycle, sets vl_o to 0 and never sets busy_o.
- R10: A start pulse while busy_o is 1 is ignored. The running operation's vl_o and the cycle in which it completes are unchanged.
- R11: vl_o is never 0 while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| vl_i | input | VL_W | Requested vector length, 0..VL_MAX |
| ffirst_i | input | 1 | Fail-first mode requested |
| vfirst_i | input | 1 | Vertical-first stepping active |
| indexed_i | input | 1 | Operation uses vector-indexed addressing |
| rsp_valid_i | input | 1 | An element access completed this cycle |
| rsp_idx_i | input | IDX_W | Element index of the completed access, ascending order |
| rsp_fault_i | input | 1 | The completed access faulted |
| wb_en_o | output | 1 | Writeback allowed for the current response |
| exc_o | output | 1 | Precise exception request (one-cycle pulse) |
| illegal_o | output | 1 | Illegal mode combination rejected (one-cycle pulse) |
| done_o | output | 1 | Operation completed (one-cycle pulse) |
| busy_o | output | 1 | Operation in progress |
| vl_o | output | VL_W | Current, possibly truncated, vector length |

## Verification
Truncation and completion can fall in the same cycle when the faulting element is also the last one of the requested length. Element-0 exception and completion coincide when the length is 1. The sweep covers every fault mask for every length, with fail-first on and off, so both collisions occur many times. In each collision the bench samples exc_o, vl_o, done_o and busy_o together in the cycle after the response and compares them with values derived from the mask arithmetic. A second instance built with the forced-length option gets the same stimulus, so its ignore-beyond-one path collides with completion as well.

// File: rtl/ff_trunc_pkg.sv
package ff_trunc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } ff_state_e;

  typedef struct packed {
    logic wb;     // writeback allowed
    logic raise;  // precise exception
    logic trunc;  // shorten VL to index
    logic fin;    // last element of original length
  } ff_dec_t;
endpackage

// File: rtl/ff_mode_decode.sv
module ff_mode_decode #(
  parameter int VL_W      = 4,
  parameter bit FORCE_VL1 = 1'b0
) (
  input  logic            ffirst_i,
  input  logic            vfirst_i,
  input  logic            indexed_i,
  input  logic [VL_W-1:0] vl_i,
  output logic            illegal_o,
  output logic            empty_o,
  output logic            run_o,
  output logic [VL_W-1:0] eff_vl_o
);
  assign illegal_o = ffirst_i & (vfirst_i | indexed_i);
  assign empty_o   = ~illegal_o & (vl_i == '0);
  assign run_o     = ~illegal_o & (vl_i != '0);

  generate
    if (FORCE_VL1) begin : g_force
      assign eff_vl_o = ffirst_i ? VL_W'(1) : vl_i;
    end else begin : g_plain
      assign eff_vl_o = vl_i;
    end
  endgenerate
endmodule

// File: rtl/ff_resp_eval.sv
module ff_resp_eval
  import ff_trunc_pkg::*;
#(
  parameter int VL_W  = 4,
  parameter int IDX_W = 3
) (
  input  logic             active_i,
  input  logic             drain_i,
  input  logic             ffirst_i,
  input  logic [VL_W-1:0]  cur_vl_i,
  input  logic [VL_W-1:0]  last_i,
  input  logic             rsp_valid_i,
  input  logic [IDX_W-1:0] rsp_idx_i,
  input  logic             rsp_fault_i,
  output ff_dec_t          dec_o
);
  logic [VL_W-1:0] idx_w;
  logic in_win, hit, bad;

  assign idx_w  = VL_W'(rsp_idx_i);
  assign in_win = idx_w < cur_vl_i;
  assign hit    = active_i & rsp_valid_i;
  assign bad    = hit & rsp_fault_i & in_win;

  always_comb begin
    dec_o       = '0;
    dec_o.wb    = hit & ~rsp_fault_i & in_win;
    dec_o.raise = bad & (~ffirst_i | (rsp_idx_i == '0));
    dec_o.trunc = bad & ffirst_i & (rsp_idx_i != '0);
    dec_o.fin   = (active_i | drain_i) & rsp_valid_i & (idx_w == last_i);
  end
endmodule

// File: rtl/ff_ctrl.sv
module ff_ctrl
  import ff_trunc_pkg::*;
#(
  parameter int VL_W  = 4,
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ffirst_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic             dec_illegal_i,
  input  logic             dec_empty_i,
  input  logic             dec_run_i,
  input  logic [VL_W-1:0]  dec_eff_vl_i,
  input  ff_dec_t          rsp_dec_i,
  input  logic [IDX_W-1:0] rsp_idx_i,
  output logic             active_o,
  output logic             drain_o,
  output logic             ffirst_o,
  output logic [VL_W-1:0]  cur_vl_o,
  output logic [VL_W-1:0]  last_o,
  output logic             exc_o,
  output logic             illegal_o,
  output logic             done_o
);
  ff_state_e       state_q;
  logic [VL_W-1:0] vl_q, last_q;
  logic            ff_q, exc_q, ill_q, done_q;
  logic            take;

  assign take = start_i & (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vl_q    <= '0;
      last_q  <= '0;
      ff_q    <= 1'b0;
      exc_q   <= 1'b0;
      ill_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      exc_q  <= 1'b0;
      ill_q  <= 1'b0;
      done_q <= 1'b0;
      if (take) begin
        if (dec_illegal_i) begin
          ill_q <= 1'b1;
        end else if (dec_empty_i) begin
          done_q <= 1'b1;
          vl_q   <= '0;
        end else if (dec_run_i) begin
          state_q <= ST_RUN;
          vl_q    <= dec_eff_vl_i;
          last_q  <= vl_i - VL_W'(1);
          ff_q    <= ffirst_i;
        end
      end else if (state_q != ST_IDLE) begin
        exc_q <= rsp_dec_i.raise;
        if (rsp_dec_i.trunc) vl_q <= VL_W'(rsp_idx_i);
        if (rsp_dec_i.fin) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else if (rsp_dec_i.raise | rsp_dec_i.trunc) begin
          state_q <= ST_DRAIN;
        end
      end
    end
  end

  assign active_o  = (state_q == ST_RUN);
  assign drain_o   = (state_q == ST_DRAIN);
  assign ffirst_o  = ff_q;
  assign cur_vl_o  = vl_q;
  assign last_o    = last_q;
  assign exc_o     = exc_q;
  assign illegal_o = ill_q;
  assign done_o    = done_q;
endmodule

// File: rtl/ff_trunc_unit.sv
module ff_trunc_unit
  import ff_trunc_pkg::*;
#(
  parameter int VL_MAX    = 8,
  parameter bit FORCE_VL1 = 1'b0,
  localparam int VL_W     = $clog2(VL_MAX + 1),
  localparam int IDX_W    = (VL_MAX > 1) ? $clog2(VL_MAX) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic             ffirst_i,
  input  logic             vfirst_i,
  input  logic             indexed_i,
  input  logic             rsp_valid_i,
  input  logic [IDX_W-1:0] rsp_idx_i,
  input  logic             rsp_fault_i,
  output logic             wb_en_o,
  output logic             exc_o,
  output logic             illegal_o,
  output logic             done_o,
  output logic             busy_o,
  output logic [VL_W-1:0]  vl_o
);
  logic            d_illegal, d_empty, d_run;
  logic [VL_W-1:0] d_eff_vl, cur_vl, last;
  logic            active, drain, ff_q;
  ff_dec_t         dec;

  ff_mode_decode #(.VL_W(VL_W), .FORCE_VL1(FORCE_VL1)) u_decode (
    .ffirst_i (ffirst_i),
    .vfirst_i (vfirst_i),
    .indexed_i(indexed_i),
    .vl_i     (vl_i),
    .illegal_o(d_illegal),
    .empty_o  (d_empty),
    .run_o    (d_run),
    .eff_vl_o (d_eff_vl)
  );

  ff_resp_eval #(.VL_W(VL_W), .IDX_W(IDX_W)) u_eval (
    .active_i   (active),
    .drain_i    (drain),
    .ffirst_i   (ff_q),
    .cur_vl_i   (cur_vl),
    .last_i     (last),
    .rsp_valid_i(rsp_valid_i),
    .rsp_idx_i  (rsp_idx_i),
    .rsp_fault_i(rsp_fault_i),
    .dec_o      (dec)
  );

  ff_ctrl #(.VL_W(VL_W), .IDX_W(IDX_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .ffirst_i     (ffirst_i),
    .vl_i         (vl_i),
    .dec_illegal_i(d_illegal),
    .dec_empty_i  (d_empty),
    .dec_run_i    (d_run),
    .dec_eff_vl_i (d_eff_vl),
    .rsp_dec_i    (dec),
    .rsp_idx_i    (rsp_idx_i),
    .active_o     (active),
    .drain_o      (drain),
    .ffirst_o     (ff_q),
    .cur_vl_o     (cur_vl),
    .last_o       (last),
    .exc_o        (exc_o),
    .illegal_o    (illegal_o),
    .done_o       (done_o)
  );

  assign wb_en_o = dec.wb;
  assign busy_o  = active | drain;
  assign vl_o    = cur_vl;
endmodule

// File: rtl/ff_trunc_chk.sv
module ff_trunc_chk #(
  parameter int VL_W      = 4,
  parameter int IDX_W     = 3,
  parameter bit FORCE_VL1 = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [VL_W-1:0]  vl_i,
  input logic             ffirst_i,
  input logic             vfirst_i,
  input logic             indexed_i,
  input logic             rsp_valid_i,
  input logic [IDX_W-1:0] rsp_idx_i,
  input logic             rsp_fault_i,
  input logic             wb_en_o,
  input logic             exc_o,
  input logic             illegal_o,
  input logic             done_o,
  input logic             busy_o,
  input logic [VL_W-1:0]  vl_o
);
  assert_exc_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> $past(busy_o && rsp_valid_i && rsp_fault_i));

  assert_vl_monotone_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (vl_o <= $past(vl_o)));

  assert_wb_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (busy_o && rsp_valid_i && !rsp_fault_i && (VL_W'(rsp_idx_i) < vl_o)));

  assert_force_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (FORCE_VL1 && $rose(busy_o) && $past(ffirst_i)) |-> (vl_o == VL_W'(1)));

  assert_illegal_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!busy_o && $past(start_i && ffirst_i && (indexed_i || vfirst_i))));

  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({illegal_o, exc_o}));

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_vl_nonzero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (vl_o != '0));
endmodule

bind ff_trunc_unit ff_trunc_chk #(.VL_W(VL_W), .IDX_W(IDX_W), .FORCE_VL1(FORCE_VL1)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .vl_i       (vl_i),
  .ffirst_i   (ffirst_i),
  .vfirst_i   (vfirst_i),
  .indexed_i  (indexed_i),
  .rsp_valid_i(rsp_valid_i),
  .rsp_idx_i  (rsp_idx_i),
  .rsp_fault_i(rsp_fault_i),
  .wb_en_o    (wb_en_o),
  .exc_o      (exc_o),
  .illegal_o  (illegal_o),
  .done_o     (done_o),
  .busy_o     (busy_o),
  .vl_o       (vl_o)
);

// File: tb/ff_trunc_unit_tb_top.sv
module ff_trunc_unit_tb_top;
  localparam int VL_MAX = 8;
  localparam int VL_W   = $clog2(VL_MAX + 1);
  localparam int IDX_W  = $clog2(VL_MAX);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, ffirst = 1'b0, vfirst = 1'b0, indexed = 1'b0;
  logic rsp_valid = 1'b0, rsp_fault = 1'b0;
  logic [VL_W-1:0]  vl = '0;
  logic [IDX_W-1:0] rsp_idx = '0;

  logic [1:0] wb, exc, ill, done, busy;
  logic [VL_W-1:0] vlo [2];

  int vectors = 0;
  int errors = 0;
  int prev_vl [2];

  always #10 clk = ~clk;

  ff_trunc_unit #(.VL_MAX(VL_MAX), .FORCE_VL1(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vl_i(vl),
    .ffirst_i(ffirst), .vfirst_i(vfirst), .indexed_i(indexed),
    .rsp_valid_i(rsp_valid), .rsp_idx_i(rsp_idx), .rsp_fault_i(rsp_fault),
    .wb_en_o(wb[0]), .exc_o(exc[0]), .illegal_o(ill[0]), .done_o(done[0]),
    .busy_o(busy[0]), .vl_o(vlo[0]));

  ff_trunc_unit #(.VL_MAX(VL_MAX), .FORCE_VL1(1'b1)) dut_f_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vl_i(vl),
    .ffirst_i(ffirst), .vfirst_i(vfirst), .indexed_i(indexed),
    .rsp_valid_i(rsp_valid), .rsp_idx_i(rsp_idx), .rsp_fault_i(rsp_fault),
    .wb_en_o(wb[1]), .exc_o(exc[1]), .illegal_o(ill[1]), .done_o(done[1]),
    .busy_o(busy[1]), .vl_o(vlo[1]));

  task automatic chk(input string req, input string what, input int k, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s inst%0d: actual %0d expected %0d", req, what, k, act, exp);
    end
  endtask

  // one operation; poke>=0 pulses a competing start at that response index
  task automatic run_op(input int n, input bit ff, input bit vf, input bit ix, input int mask, input int poke);
    int eff [2];
    bit alive [2];
    @(negedge clk);
    start = 1'b1; vl = VL_W'(n); ffirst = ff; vfirst = vf; indexed = ix;
    @(negedge clk);
    start = 1'b0;
    if (ff && (vf || ix)) begin
      for (int k = 0; k < 2; k++) begin
        chk("R8", "illegal", k, int'(ill[k]), 1);
        chk("R8", "busy", k, int'(busy[k]), 0);
        chk("R8", "vl", k, int'(vlo[k]), prev_vl[k]);
      end
      @(negedge clk);
      for (int k = 0; k < 2; k++) chk("R8", "illegal pulse", k, int'(ill[k]), 0);
      return;
    end
    if (n == 0) begin
      for (int k = 0; k < 2; k++) begin
        chk("R9", "empty done", k, int'(done[k]), 1);
        chk("R9", "empty busy", k, int'(busy[k]), 0);
        chk("R9", "empty vl", k, int'(vlo[k]), 0);
        prev_vl[k] = 0;
      end
      return;
    end
    for (int k = 0; k < 2; k++) begin
      eff[k] = (k == 1 && ff) ? 1 : n;   // R7 forced length
      alive[k] = 1'b1;
      chk("R7", "start vl", k, int'(vlo[k]), eff[k]);
      chk("R9", "start busy", k, int'(busy[k]), 1);
    end
    for (int i = 0; i < n; i++) begin
      bit f;
      int exp_exc [2];
      f = mask[i];
      rsp_valid = 1'b1; rsp_idx = IDX_W'(i); rsp_fault = f;
      if (i == poke) begin
        start = 1'b1; vl = VL_W'(1); ffirst = 1'b0;
      end
      #1;
      for (int k = 0; k < 2; k++) begin
        chk("R5", "wb", k, int'(wb[k]), int'(alive[k] && !f && i < eff[k]));
        exp_exc[k] = 0;
        if (alive[k] && f && i < eff[k]) begin
          if (!ff || i == 0) exp_exc[k] = 1;   // R2, R6
          else eff[k] = i;                    // R3
          alive[k] = 1'b0;
        end
      end
      @(negedge clk);
      rsp_valid = 1'b0; start = 1'b0;
      for (int k = 0; k < 2; k++) begin
        chk(ff ? (i == 0 ? "R2" : "R3_R4") : "R6", "exc", k, int'(exc[k]), exp_exc[k]);
        chk(ff ? "R3_R4" : "R6", "vl", k, int'(vlo[k]), eff[k]);
        chk(i == poke ? "R10" : "R9", "done", k, int'(done[k]), int'(i == n - 1));
        chk("R9", "busy", k, int'(busy[k]), int'(i != n - 1));
      end
    end
    for (int k = 0; k < 2; k++) prev_vl[k] = eff[k];
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    prev_vl[0] = 0; prev_vl[1] = 0;
    #5;
    for (int k = 0; k < 2; k++) begin
      chk("R1", "busy", k, int'(busy[k]), 0);
      chk("R1", "done", k, int'(done[k]), 0);
      chk("R1", "exc", k, int'(exc[k]), 0);
      chk("R1", "illegal", k, int'(ill[k]), 0);
      chk("R1", "wb", k, int'(wb[k]), 0);
      chk("R1", "vl", k, int'(vlo[k]), 0);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int n = 1; n <= VL_MAX; n++)
      for (int ff = 0; ff < 2; ff++)
        for (int m = 0; m < (1 << n); m++)
          run_op(n, ff[0], 1'b0, 1'b0, m, -1);
    // legal mode flags without fail-first
    run_op(5, 1'b0, 1'b1, 1'b1, 5'b00100, -1);
    // R8 illegal combinations
    run_op(4, 1'b1, 1'b1, 1'b0, 0, -1);
    run_op(4, 1'b1, 1'b0, 1'b1, 0, -1);
    run_op(6, 1'b1, 1'b1, 1'b1, 0, -1);
    // R9 empty operation
    run_op(0, 1'b1, 1'b0, 1'b0, 0, -1);
    run_op(0, 1'b0, 1'b0, 1'b0, 0, -1);
    // R10 competing start mid-operation
    run_op(6, 1'b1, 1'b0, 1'b0, 6'b010000, 2);
    run_op(6, 1'b0, 1'b0, 1'b0, 6'b000000, 0);
    run_op(8, 1'b1, 1'b0, 1'b0, 8'b00001000, 5);
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule